// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the leading bytes of a received Ethernet frame as they arrive one per cycle. It collects the six-byte destination address and, after the sixth byte, gives a keep-or-drop verdict and the reason for it. The verdict is based on a small set of configuration registers: a receive switch, a promiscuous switch, a multicast hash switch, the station's own 48-bit address and a 64-bin multicast hash table. The receive path downstream uses the verdict to decide whether the rest of the frame goes to memory.

The address is compared against the station address and against the all-ones broadcast address as the bytes arrive. A reflected CRC-32 runs over the same bytes. Its top six bits pick one bin of the hash table. The verdict is registered and stays on the outputs until the next frame begins, so a slow consumer can read it late.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_kind` are 0 and all configuration registers are cleared. Until software sets the receive switch, every frame is therefore rejected.
- R2: While control bit 0 (receive enable) is 0, every frame is rejected with kind 0, even if the promiscuous or hash switches are set.
- R3: While receive is enabled and control bit 6 (promiscuous) is 1, every frame of six or more bytes is accepted with kind 4.
- R4: Selects 1, 2 and 3 hold station address bytes (0,1), (2,3) and (4,5), with the lower-numbered byte in bits 15:8 and the other in bits 7:0. Destination byte 0 is the first byte received. A full match accepts the frame with kind 1.
- R5: A destination of six 0xFF bytes that does not match the station address is accepted with kind 2.
- R6: With control bit 11 (hash enable) set, the hash index is bits 31:26 of a reflected CRC-32 (polynomial 0xEDB88320, preset all ones, LSB of each byte first, no final inversion) over the six destination bytes. Hash word w (select 4+w) holds bins 16w..16w+15, with bin 16w+b in bit b. A set bin accepts the frame with kind 3.
- R7: A destination that matches neither the station address nor broadcast is rejected if hash enable is clear or its bin is clear.
- R8: The checks are ranked as enable, then promiscuous, then station, then broadcast, then hash. `dec_kind` reports the first one that hits. `dec_accept` is 1 exactly when `dec_kind` is not 0.
- R9: Exactly one `dec_valid` pulse is produced per frame. It comes in the cycle after the sixth byte is taken. Bytes after the sixth, and bytes outside a frame, have no effect.
- R10: A frame whose last byte (`in_last`) comes before the sixth byte gives a reject pulse in the cycle after that last byte.
- R11: `dec_accept` and `dec_kind` keep their values until the next byte marked `in_first`. They read 0 in the cycle after it, until that frame's verdict.
- R12: A configuration write takes effect on the clock edge where `cfg_we` is high. Select 0 is the control register, selects 1 to 3 are station address registers, and selects 4 to 7 are hash words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Frame byte present |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop (held) |
| dec_kind | output | 3 | Reason: 0 none, 1 station, 2 broadcast, 3 hash, 4 promiscuous (held) |

## Verification
The assertions assume that `in_first` and `in_last` are only meaningful when `in_valid` is high. They also assume the configuration is not rewritten in the cycle a verdict forms, because the verdict uses the register values of that cycle. The stimulus keeps to this by writing configuration only between frames, with idle cycles around each write. It covers frames of one, three, six and ten bytes, back-to-back bytes, and a byte marked both first and last.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    MK_NONE    = 3'd0,
    MK_STATION = 3'd1,
    MK_BCAST   = 3'd2,
    MK_HASH    = 3'd3,
    MK_PROMISC = 3'd4
  } match_kind_e;

  // One byte through the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in,
                                           input logic [7:0]  d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_da_cfg_regs.sv
module rx_da_cfg_regs #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_WORDS = 4,
  parameter int WORD_W     = 16,
  parameter int BYTE_W     = 8,
  localparam int STA_REGS  = ADDR_BYTES / 2,
  localparam int SEL_W     = $clog2(1 + STA_REGS + HASH_WORDS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [SEL_W-1:0]               sel,
  input  logic [WORD_W-1:0]              wdata,
  output logic                           rx_en,
  output logic                           promisc,
  output logic                           hash_en,
  output logic [ADDR_BYTES*BYTE_W-1:0]   station,
  output logic [HASH_WORDS*WORD_W-1:0]   hash_flat
);

  localparam int BIT_EN   = 0;
  localparam int BIT_PROM = 6;
  localparam int BIT_HASH = 11;

  logic [WORD_W-1:0] sta_q  [STA_REGS];
  logic [WORD_W-1:0] hash_q [HASH_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en   <= 1'b0;
      promisc <= 1'b0;
      hash_en <= 1'b0;
    end else if (we && sel == '0) begin
      rx_en   <= wdata[BIT_EN];
      promisc <= wdata[BIT_PROM];
      hash_en <= wdata[BIT_HASH];
    end
  end

  for (genvar j = 0; j < STA_REGS; j++) begin : g_sta
    always_ff @(posedge clk) begin
      if (rst)                               sta_q[j] <= '0;
      else if (we && sel == SEL_W'(1 + j))   sta_q[j] <= wdata;
    end
    // Lower-numbered byte of each pair sits in the upper half.
    assign station[(2*j)*BYTE_W   +: BYTE_W] = sta_q[j][WORD_W-1 -: BYTE_W];
    assign station[(2*j+1)*BYTE_W +: BYTE_W] = sta_q[j][BYTE_W-1:0];
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk) begin
      if (rst)                                          hash_q[w] <= '0;
      else if (we && sel == SEL_W'(1 + STA_REGS + w))   hash_q[w] <= wdata;
    end
    assign hash_flat[w*WORD_W +: WORD_W] = hash_q[w];
  end

endmodule

// File: rtl/rx_da_track.sv
module rx_da_track
  import rx_da_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 6,
  localparam int CW        = $clog2(ADDR_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_first,
  input  logic                         in_last,
  input  logic [BYTE_W-1:0]            in_data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station,
  output logic                         decide_full,
  output logic                         decide_short,
  output logic                         station_hit,
  output logic                         bcast_hit,
  output logic [IDX_W-1:0]             hash_idx
);

  logic [CW-1:0] cnt_q, pos;
  logic          busy_q, live, at_end, lead;
  logic          stn_q, bc_q, stn_nx, bc_nx;
  logic [31:0]   crc_q, crc_in, crc_nx;

  assign live   = in_valid && (in_first || busy_q);
  assign pos    = in_first ? '0 : cnt_q;
  assign lead   = (pos == '0);
  assign at_end = (pos == CW'(ADDR_BYTES - 1));

  assign decide_full  = live && at_end;
  assign decide_short = live && !at_end && in_last;

  assign stn_nx = (lead | stn_q) & (in_data == station[pos*BYTE_W +: BYTE_W]);
  assign bc_nx  = (lead | bc_q)  & (&in_data);
  assign crc_in = lead ? 32'hFFFF_FFFF : crc_q;
  assign crc_nx = crc_byte(crc_in, in_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      stn_q  <= 1'b0;
      bc_q   <= 1'b0;
      crc_q  <= '0;
    end else if (live) begin
      busy_q <= !(decide_full || decide_short);
      cnt_q  <= pos + 1'b1;
      stn_q  <= stn_nx;
      bc_q   <= bc_nx;
      crc_q  <= crc_nx;
    end
  end

  assign station_hit = stn_nx;
  assign bcast_hit   = bc_nx;
  assign hash_idx    = crc_nx[31 -: IDX_W];

  // R9: the byte position never runs past the address while a frame is open.
  p_pos_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CW'(ADDR_BYTES)));

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_WORDS = 4,
  parameter int WORD_W     = 16,
  parameter int BYTE_W     = 8,
  localparam int STA_REGS  = ADDR_BYTES / 2,
  localparam int SEL_W     = $clog2(1 + STA_REGS + HASH_WORDS),
  localparam int IDX_W     = $clog2(HASH_WORDS * WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [BYTE_W-1:0] in_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_kind
);

  logic                          cfg_en, cfg_prom, cfg_hen;
  logic [ADDR_BYTES*BYTE_W-1:0]  station;
  logic [HASH_WORDS*WORD_W-1:0]  hash_flat;
  logic                          decide_full, decide_short, decide;
  logic                          station_hit, bcast_hit, hash_hit;
  logic [IDX_W-1:0]              hash_idx;
  match_kind_e                   kind_nx, kind_q;
  logic                          acc_q;

  rx_da_cfg_regs #(
    .ADDR_BYTES(ADDR_BYTES), .HASH_WORDS(HASH_WORDS),
    .WORD_W(WORD_W), .BYTE_W(BYTE_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rx_en(cfg_en), .promisc(cfg_prom), .hash_en(cfg_hen),
    .station(station), .hash_flat(hash_flat)
  );

  rx_da_track #(
    .ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .station(station),
    .decide_full(decide_full), .decide_short(decide_short),
    .station_hit(station_hit), .bcast_hit(bcast_hit), .hash_idx(hash_idx)
  );

  // Word w covers bins 16w..16w+15, so the flat table is indexed directly.
  assign hash_hit = hash_flat[hash_idx];
  assign decide   = decide_full || decide_short;

  always_comb begin
    if (decide_short || !cfg_en) kind_nx = MK_NONE;
    else if (cfg_prom)           kind_nx = MK_PROMISC;
    else if (station_hit)        kind_nx = MK_STATION;
    else if (bcast_hit)          kind_nx = MK_BCAST;
    else if (cfg_hen && hash_hit) kind_nx = MK_HASH;
    else                         kind_nx = MK_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      kind_q    <= MK_NONE;
      acc_q     <= 1'b0;
    end else begin
      dec_valid <= decide;
      if (decide) begin
        kind_q <= kind_nx;
        acc_q  <= (kind_nx != MK_NONE);
      end else if (in_valid && in_first) begin
        kind_q <= MK_NONE;
        acc_q  <= 1'b0;
      end
    end
  end

  assign dec_accept = acc_q;
  assign dec_kind   = kind_q;

  // R8: accept flag and reason code agree.
  p_kind_agree_r8: assert property (@(posedge clk) disable iff (rst)
    dec_accept == (dec_kind != 3'd0));

  // R2: a verdict formed while receive was off is a reject.
  p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !$past(cfg_en)) |-> !dec_accept);

  // R10: a frame cut short yields a reject strobe next cycle.
  p_short_r10: assert property (@(posedge clk) disable iff (rst)
    decide_short |=> (dec_valid && !dec_accept));

  // R11: with neither a verdict nor a frame start, the verdict holds.
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!decide && !(in_valid && in_first)) |=> ($stable(dec_accept) && $stable(dec_kind)));

  // R9: a strobe always follows an accepted input byte.
  p_strobe_src_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(in_valid));

  // R6: a hash verdict needs hash enable in the deciding cycle.
  p_hash_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == 3'd3) |-> $past(cfg_hen));

endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        in_valid, in_first, in_last;
  logic [7:0]  in_data;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_kind;

  always #4 clk = ~clk;

  rx_da_filter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_kind(dec_kind)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side view of configuration.
  logic        sh_en = 0, sh_prom = 0, sh_hen = 0;
  logic [47:0] sh_sta = '0;
  logic [63:0] sh_hash = '0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] da_byte(input logic [47:0] da, input int k);
    return da[47 - 8*k -: 8];
  endfunction

  function automatic logic [5:0] bench_idx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ da[40 - 8*(i/8) + (i%8)];
      c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return c[31:26];
  endfunction

  // Expected {accept, kind} from the requirements.
  function automatic logic [3:0] model(input logic [47:0] da, input int len);
    logic [2:0] k;
    if (len < 6 || !sh_en)              k = 3'd0;
    else if (sh_prom)                   k = 3'd4;
    else if (da == sh_sta)              k = 3'd1;
    else if (da == 48'hFFFF_FFFF_FFFF)  k = 3'd2;
    else if (sh_hen && sh_hash[bench_idx(da)]) k = 3'd3;
    else                                k = 3'd0;
    return {k != 3'd0, k};
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel == 3'd0) begin
      sh_en = d[0]; sh_prom = d[6]; sh_hen = d[11];
    end else if (sel <= 3'd3) begin
      sh_sta[47 - 16*(sel-1) -: 16] = d;
    end else begin
      sh_hash[16*(sel-4) +: 16] = d;
    end
  endtask

  task automatic set_station(input logic [47:0] da);
    for (int j = 0; j < 3; j++)
      cfg_write(3'(1 + j), {da_byte(da, 2*j), da_byte(da, 2*j + 1)});
  endtask

  // Driver: push expectation, then present the frame byte by byte.
  task automatic send(input logic [47:0] da, input int len, input string tag,
                      input bit chk_clear);
    exp_q.push_back(model(da, len));
    tag_q.push_back(tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (chk_clear && i == 1) begin
        check("R11 cleared by start accept", {7'd0, dec_accept}, 8'd0);
        check("R11 cleared by start kind", {5'd0, dec_kind}, 8'd0);
      end
      in_valid = 1; in_first = (i == 0); in_last = (i == len - 1);
      in_data  = (i < 6) ? da_byte(da, i) : 8'(i);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each strobe with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9 unexpected strobe actual=1 expected=0");
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {4'd0, dec_accept, dec_kind}, {4'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  localparam logic [47:0] STA   = 48'h0212_3456_789A;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC    = 48'h0100_5E00_0001;
  localparam logic [47:0] OTHER = 48'h0A0B_0C0D_0E0F;

  initial begin
    logic [5:0] idx;
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    in_valid = 0; in_first = 0; in_last = 0; in_data = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset valid",  {7'd0, dec_valid}, 8'd0);
    check("R1 reset accept", {7'd0, dec_accept}, 8'd0);
    check("R1 reset kind",   {5'd0, dec_kind}, 8'd0);

    send(BCAST, 6, "R1 cleared config rejects", 0);

    // R2: switches set but receive off.
    cfg_write(3'd0, 16'h0840);
    send(BCAST, 8, "R2 disabled promisc", 0);

    // R12/R4: station programming, exact match.
    cfg_write(3'd0, 16'h0001);
    set_station(STA);
    send(STA, 6, "R4 station match", 0);
    send(STA ^ 48'h1, 6, "R7 near miss rejected", 0);
    send(STA ^ 48'h0100_0000_0000, 6, "R4 first byte differs", 0);

    // R5: broadcast.
    send(BCAST, 10, "R5 broadcast", 0);
    check("R11 held after frame accept", {7'd0, dec_accept}, 8'd1);
    check("R11 held after frame kind", {5'd0, dec_kind}, 8'd2);
    send(OTHER, 7, "R7 hash off rejects", 1);

    // R6: hash hit in the computed bin.
    idx = bench_idx(MC);
    cfg_write(3'(4 + idx[5:4]), 16'(1) << idx[3:0]);
    send(MC, 6, "R7 bin set but hash disabled", 0);
    cfg_write(3'd0, 16'h0801);
    send(MC, 6, "R6 hash bin hit", 0);
    cfg_write(3'(4 + idx[5:4]), ~(16'(1) << idx[3:0]));
    send(MC, 6, "R7 hash bin clear", 0);
    for (int w = 0; w < 4; w++) cfg_write(3'(4 + w), 16'hFFFF);
    send(OTHER, 6, "R6 full table", 0);

    // R8: priority.
    send(BCAST, 6, "R8 broadcast over hash", 0);
    set_station(BCAST);
    send(BCAST, 6, "R8 station over broadcast", 1);
    cfg_write(3'd0, 16'h0841);
    send(BCAST, 6, "R8 promisc over station", 0);

    // R3: promiscuous takes anything.
    for (int w = 0; w < 4; w++) cfg_write(3'(4 + w), 16'h0000);
    cfg_write(3'd0, 16'h0041);
    send(OTHER, 6, "R3 promisc accepts", 0);

    // R10: short frames.
    send(OTHER, 3, "R10 three byte frame", 0);
    send(OTHER, 1, "R10 single byte frame", 0);

    // R9: stray bytes outside a frame do nothing.
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1; in_first = 0; in_last = 0; in_data = 8'hFF;
    end
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    check("R9 no strobes outside frame", 8'(exp_q.size()), 8'd0);
    check("R9 stray bytes leave verdict", {5'd0, dec_kind}, 8'd0);

    send(OTHER, 6, "R3 promisc after stray", 0);
    check("R9 scoreboard drained", 8'(exp_q.size()), 8'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule